// File: doc/BRIEF.md
# Masked-Stride DMA Address Generator

This block supplies the running address for one side (source or destination) of a DMA channel. A load pulse copies a 32-bit start address into the current-address register. Each advance strobe, one per write cycle of the transfer, moves the address by a signed 8-bit step. The register value is always visible on the output and names the location used by the transfer in progress.

The four most significant address bits stay fixed at their loaded value, so the address wraps inside a 256 MB window and never carries into the top nibble. A 24-bit hold mask covers address bits 27 down to 4. Each set mask bit freezes its address bit, so a group of frozen upper bits with free lower bits gives a circular buffer with no length register. The sum is always formed over the full 28 bits. Masked positions are then restored from the old address, so carries still pass through them.

Top module: `dma_agen`

## Requirements
- R1: While rst_ni is low, addr_o is 0x00000000 and valid_o is 0.
- R2: A load_i high at a rising edge places start_addr_i on addr_o after that edge and sets valid_o to 1. valid_o stays 1 until reset.
- R3: When load_i and adv_i are both high at the same edge, the load wins. addr_o equals start_addr_i and the step is not applied.
- R4: An adv_i high at an edge (with load_i low) adds step_i to the address. step_i is 8-bit two's complement, and bit 7 = 0 means a forward move.
- R5: When step_i bit 7 is 1, the address moves backward by the two's-complement magnitude (0xFF = -1, 0xF0 = -16).
- R6: Address bits 31:28 never change except on a load. A carry out of bit 27 is dropped, so 0x7FFFFFFF + 1 gives 0x70000000.
- R7: A borrow below the window base wraps inside the window, so 0x40000000 - 1 gives 0x4FFFFFFF.
- R8: Mask bit k (k = 0..23) holds address bit k+4 at its old value on an advance. The new low 28 bits are (sum & ~mask28) | (old & mask28), where mask28 = {mask_i, 4'b0}. The carry still passes through held bits.
- R9: Address bits 3:0 have no mask bit and always take the arithmetic result, even with mask_i all ones.
- R10: An advance with step_i = 0 leaves addr_o unchanged (fixed-port mode).
- R11: With both load_i and adv_i low, addr_o holds its value whatever step_i and mask_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Copy start address into the register |
| start_addr_i | input | 32 | Start address |
| adv_i | input | 1 | Advance strobe, one per write cycle |
| step_i | input | 8 | Signed step |
| mask_i | input | 24 | Hold mask for address bits 27:4 |
| addr_o | output | 32 | Current address |
| valid_o | output | 1 | Address has been loaded |

## Verification
Every result is due one clock edge after its stimulus, because addr_o and valid_o come straight from the register. Each task drives its inputs on a falling edge, lets one rising edge pass, and samples at the next falling edge. At that point the value reflects exactly one load or advance. The hold and no-effect checks sample again after further idle edges, to show that nothing moved.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned STEP_W = 8;
  localparam int unsigned MASK_W = 24;
  localparam int unsigned FREE_W = 4;
endpackage

// File: rtl/dma_agen_step.sv
// Sign-extended step added over the wrap window; carry out is dropped.
module dma_agen_step #(
  parameter int unsigned SPAN_W = 28,
  parameter int unsigned STEP_W = 8
) (
  input  logic [SPAN_W-1:0] base_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [SPAN_W-1:0] sum_o
);
  logic [SPAN_W-1:0] step_ext;
  assign step_ext = {{(SPAN_W-STEP_W){step_i[STEP_W-1]}}, step_i};
  assign sum_o    = base_i + step_ext;
endmodule

// File: rtl/dma_agen_merge.sv
// Restore held bits from the old address; low FREE_W bits always follow the sum.
module dma_agen_merge #(
  parameter int unsigned MASK_W = 24,
  parameter int unsigned FREE_W = 4,
  localparam int unsigned SPAN_W = MASK_W + FREE_W
) (
  input  logic [SPAN_W-1:0] sum_i,
  input  logic [SPAN_W-1:0] old_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [SPAN_W-1:0] next_o
);
  assign next_o[FREE_W-1:0] = sum_i[FREE_W-1:0];
  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    assign next_o[FREE_W+i] = mask_i[i] ? old_i[FREE_W+i] : sum_i[FREE_W+i];
  end
endmodule

// File: rtl/dma_agen.sv
module dma_agen
  import dma_agen_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned SW = STEP_W,
  parameter int unsigned MW = MASK_W,
  parameter int unsigned FW = FREE_W,
  localparam int unsigned SPAN_W = MW + FW,
  localparam int unsigned TOP_W  = AW - SPAN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          adv_i,
  input  logic [SW-1:0] step_i,
  input  logic [MW-1:0] mask_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o
);
  logic [AW-1:0]     addr_q;
  logic              valid_q;
  logic [SPAN_W-1:0] sum;
  logic [SPAN_W-1:0] next_span;

  dma_agen_step #(.SPAN_W(SPAN_W), .STEP_W(SW)) u_step (
    .base_i (addr_q[SPAN_W-1:0]),
    .step_i (step_i),
    .sum_o  (sum)
  );

  dma_agen_merge #(.MASK_W(MW), .FREE_W(FW)) u_merge (
    .sum_i  (sum),
    .old_i  (addr_q[SPAN_W-1:0]),
    .mask_i (mask_i),
    .next_o (next_span)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      addr_q  <= start_addr_i;
      valid_q <= 1'b1;
    end else if (adv_i) begin
      addr_q[SPAN_W-1:0] <= next_span;
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = valid_q;

  // R2
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(start_addr_i)) && valid_o);

  // R2
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  // R6
  top_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> addr_o[AW-1:AW-TOP_W] == $past(addr_o[AW-1:AW-TOP_W]));

  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=>
      (((addr_o[SPAN_W-1:FW] ^ $past(addr_o[SPAN_W-1:FW])) & $past(mask_i)) == '0));

  // R10
  zero_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && step_i == '0) |=> $stable(addr_o));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(addr_o));
endmodule

// File: tb/dma_agen_test.sv
`timescale 1ns/1ps
module dma_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] start = '0;
  logic        adv = 1'b0;
  logic [7:0]  step = '0;
  logic [23:0] mask = '0;
  logic [31:0] addr;
  logic        valid;
  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_agen uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .start_addr_i(start),
    .adv_i(adv), .step_i(step), .mask_i(mask), .addr_o(addr), .valid_o(valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  // One edge with given controls, sample at following falling edge.
  task automatic cyc(input logic ld, input logic [31:0] sa, input logic av,
                     input logic [7:0] st, input logic [23:0] mk);
    @(negedge clk);
    load = ld; start = sa; adv = av; step = st; mask = mk;
    @(negedge clk);
    load = 1'b0; adv = 1'b0;
  endtask

  function automatic logic [31:0] model(input logic [31:0] old, input logic [7:0] st,
                                        input logic [23:0] mk);
    logic [27:0] s, m;
    s = old[27:0] + {{20{st[7]}}, st};
    m = {mk, 4'b0};
    return {old[31:28], (s & ~m) | (old[27:0] & m)};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk("R1 addr", addr, 32'h0);
    chk("R1 valid", {31'b0, valid}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_load;
    cyc(1, 32'h1234_5678, 0, 8'h00, '0);
    chk("R2 addr", addr, 32'h1234_5678);
    chk("R2 valid", {31'b0, valid}, 32'h1);
    cyc(0, 32'h0, 1, 8'h04, '0);
    chk("R2 valid sticky", {31'b0, valid}, 32'h1);
  endtask

  task automatic t_prio;
    cyc(1, 32'hA000_0100, 1, 8'h04, '0);
    chk("R3 load wins", addr, 32'hA000_0100);
  endtask

  task automatic t_fwd;
    cyc(1, 32'h5000_0000, 0, 8'h00, '0);
    cyc(0, 32'h0, 1, 8'h7F, '0);
    chk("R4 +127", addr, 32'h5000_007F);
    cyc(0, 32'h0, 1, 8'h7F, '0);
    chk("R4 +127 again", addr, 32'h5000_00FE);
  endtask

  task automatic t_back;
    cyc(1, 32'h4000_0010, 0, 8'h00, '0);
    cyc(0, 32'h0, 1, 8'hF0, '0);
    chk("R5 -16", addr, 32'h4000_0000);
    cyc(0, 32'h0, 1, 8'hFF, '0);
    chk("R7 underflow wrap", addr, 32'h4FFF_FFFF);
  endtask

  task automatic t_over;
    cyc(1, 32'h7FFF_FFFF, 0, 8'h00, '0);
    cyc(0, 32'h0, 1, 8'h01, '0);
    chk("R6 overflow wrap", addr, 32'h7000_0000);
  endtask

  task automatic t_mask;
    cyc(1, 32'h1234_56F8, 0, 8'h00, '0);
    cyc(0, 32'h0, 1, 8'h08, 24'hFFFFF0);
    chk("R8 circular wrap", addr, 32'h1234_5600);
    cyc(1, 32'h3000_001F, 0, 8'h00, '0);
    cyc(0, 32'h0, 1, 8'h01, 24'h000001);
    chk("R8 carry through held bit", addr, 32'h3000_0030);
  endtask

  task automatic t_low;
    cyc(1, 32'h1000_000E, 0, 8'h00, '0);
    cyc(0, 32'h0, 1, 8'h03, 24'hFFFFFF);
    chk("R9 low nibble free", addr, 32'h1000_0001);
  endtask

  task automatic t_zero;
    cyc(1, 32'h2ABC_DEF0, 0, 8'h00, '0);
    for (int i = 0; i < 3; i++) cyc(0, 32'h0, 1, 8'h00, 24'h00000F);
    chk("R10 zero step", addr, 32'h2ABC_DEF0);
  endtask

  task automatic t_idle;
    cyc(1, 32'h6000_0040, 0, 8'h00, '0);
    cyc(0, 32'hFFFF_FFFF, 0, 8'h80, 24'hABCDEF);
    cyc(0, 32'h1111_1111, 0, 8'h11, 24'h000000);
    chk("R11 idle hold", addr, 32'h6000_0040);
  endtask

  task automatic t_walk;
    logic [31:0] exp;
    logic [15:0] lf;
    lf = 16'hACE1;
    cyc(1, 32'h9FFF_FF80, 0, 8'h00, '0);
    exp = 32'h9FFF_FF80;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(0, 32'h0, 1, lf[7:0], {lf[15:8], lf[15:8], lf[15:8]} & 24'hF0F00F);
      exp = model(exp, lf[7:0], {lf[15:8], lf[15:8], lf[15:8]} & 24'hF0F00F);
      chk("R8 walk", addr, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (2) @(negedge clk);
        t_reset;
        t_load;
        t_prio;
        t_fwd;
        t_back;
        t_over;
        t_mask;
        t_low;
        t_zero;
        t_idle;
        t_walk;
      end
      begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog act=%08h exp=%08h", 32'h0, 32'h1);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule